// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Wakeup

This block gathers interrupt events from on-chip sources, a peripheral group, one configurable external pin, a nonmaskable pin and two CPU trap strobes. Each maskable event sets a pending bit. Pending bits are gated by per-source mask bits and by a global enable. The highest-priority survivor goes into a one-entry output slot, which the CPU drains through a valid/ready handshake carrying a vector index.

The output slot follows stream rules. Once `vec_valid` rises, `vec_id` holds still until the cycle in which `vec_ready` is high, and that accepting cycle clears the source's pending flag. `vec_valid` then drops for one cycle before the next vector is offered. The CPU may hold `vec_ready` low for as long as it likes, and a higher-priority event that arrives in the meantime waits behind the vector already offered.

Software reaches masks, pending bits and configuration through a small address/data register bus with a combinational read path. In the low-power modes the block drives a wakeup level and, on powerdown exit, a flag that tells the CPU whether a service routine should run or execution should simply resume.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset, `vec_valid`, `wake` and `wake_service` are 0, and every register reads 0. The register addresses are: 0 mask of sources 0-7, 1 pending of sources 0-7, 2 mask of sources 8-15, 3 pending of sources 8-15, 4 peripheral mask, 5 control. Control bit 0 is the global enable, bit 1 selects level mode, and bit 2 selects active-high/rising polarity.
- R2: A high cycle on `irq_src[i]` sets pending bit i, and bit i reads back at bit position i mod 8 of address 1 or 3. Writing 0 to a pending bit clears it, and writing 1 has no effect.
- R3: When a hardware set and a software clear of the same pending bit fall in the same cycle, the bit ends up set.
- R4: Maskable source i is offered only when its pending bit, its mask bit and the global enable are all 1. Among the offered sources the higher index wins, and `vec_id` equals the source index.
- R5: While `vec_valid` is high and `vec_ready` is low, `vec_id` stays stable. In an accepting cycle the pending flag of that vector clears, and `vec_valid` is low in the next cycle.
- R6: `peri_req[k]` sets pending bit 5 only when bit k of the peripheral mask (address 4) is 1.
- R7: In edge mode (control bit 1 = 0), each rising edge of `ext_pin` (polarity 1) or falling edge (polarity 0) sets pending bit 2 once. The pin passes through a two-flop synchronizer first.
- R8: In level mode, pending bit 2 is set again every cycle while `ext_pin` sits at its active level, so a software clear does not stick until the pin goes inactive.
- R9: Vector 18 is offered when `nmi_pin` rises and then stays high for at least two samples in run mode (`pwr_mode` = 0). A one-cycle pulse is ignored, and an edge seen outside run mode is ignored. This vector has no mask and does not depend on the global enable.
- R10: `trap_unimpl` gives vector 16 and `trap_sw` gives vector 17, and neither can be masked. The priority order is vector 18 > 16 > 17 > maskable sources.
- R11: In idle mode (`pwr_mode` = 1), `wake` is high whenever some pending bit has its mask bit set.
- R12: In powerdown mode (`pwr_mode` = 2), `wake` follows pending bit 2 regardless of its mask. `wake_service` equals `wake` ANDed with mask bit 2. In run mode both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 16 | On-chip source events, one-cycle high pulses |
| peri_req | input | 5 | Peripheral group events, merged into source 5 |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| nmi_pin | input | 1 | Nonmaskable interrupt pin, asynchronous |
| trap_sw | input | 1 | Software trap strobe |
| trap_unimpl | input | 1 | Unimplemented-opcode trap strobe |
| pwr_mode | input | 2 | 0 run, 1 idle, 2 powerdown |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| vec_valid | output | 1 | Vector offered to the CPU |
| vec_ready | input | 1 | CPU accepts the offered vector |
| vec_id | output | 5 | Vector index |
| wake | output | 1 | Wakeup request from idle or powerdown |
| wake_service | output | 1 | Powerdown exit should run the service routine |

## Verification
The bench sweeps pending and mask patterns and drains every vector. It checks strict descending order, so an arbiter that lets the lower index win, or one that ignores a mask bit, shows up as a wrong `vec_id` or an extra vector. The bench presents the traps and the nonmaskable event while an earlier vector sits unaccepted. A design that replaces the held vector, or that orders the unmaskable vectors wrongly, fails the drain sequence. Further checks cover:
- a one-cycle glitch on the nonmaskable pin, and an edge in powerdown, both of which must produce no vector;
- a software clear colliding with a hardware set, where the bit must end up set;
- a level-mode clear that must not stick while the pin is active;
- powerdown wakeup with the external mask bit cleared, where a design that gates wakeup with the mask stays asleep.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_PEND_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_PEND_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_PERI    = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd5;

  localparam int CTRL_W     = 3;
  localparam int CTRL_GIE   = 0;
  localparam int CTRL_LEVEL = 1;
  localparam int CTRL_POL   = 2;

  localparam logic [1:0] PM_RUN  = 2'd0;
  localparam logic [1:0] PM_IDLE = 2'd1;
  localparam logic [1:0] PM_DOWN = 2'd2;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/icu_cond.sv
module icu_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_s,
  input  logic nmi_s,
  input  logic level_mode,
  input  logic pol_high,
  input  logic run_mode,
  output logic ext_evt,
  output logic nmi_evt
);
  logic ext_d, nmi_d, nmi_filt_q;
  logic act_now, act_prev, nmi_filt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_d      <= 1'b0;
      nmi_d      <= 1'b0;
      nmi_filt_q <= 1'b0;
    end else begin
      ext_d      <= ext_s;
      nmi_d      <= nmi_s;
      nmi_filt_q <= nmi_filt;
    end
  end

  always_comb begin
    act_now  = pol_high ? ext_s : ~ext_s;
    act_prev = pol_high ? ext_d : ~ext_d;
    ext_evt  = level_mode ? act_now : (act_now & ~act_prev);
    // two consecutive high samples are needed before the edge counts
    nmi_filt = nmi_s & nmi_d;
    nmi_evt  = run_mode & nmi_filt & ~nmi_filt_q;
  end
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int NPERI      = 5,
  parameter int EXT_IDX    = 2,
  parameter int PERI_IDX   = 5,
  parameter int VEC_W      = 5,
  parameter int VEC_UNIMPL = 16,
  parameter int VEC_SW     = 17,
  parameter int VEC_NMI    = 18,
  localparam int NSRC      = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic [NPERI-1:0]  peri_req,
  input  logic              ext_evt,
  input  logic              nmi_evt,
  input  logic              trap_sw,
  input  logic              trap_unimpl,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ack,
  input  logic [VEC_W-1:0]  ack_id,
  output logic [NSRC-1:0]   pend_o,
  output logic [NSRC-1:0]   mask_o,
  output logic              gie_o,
  output logic              ext_level_o,
  output logic              ext_pol_o,
  output logic              nmi_p_o,
  output logic              unimpl_p_o,
  output logic              sw_p_o
);
  logic [NSRC-1:0]   pend_q, mask_q, set_v, clr_sw, clr_ack, pend_d;
  logic [NPERI-1:0]  peri_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              nmi_q, unimpl_q, sw_q;
  logic              ack_nmi, ack_unimpl, ack_sw;

  always_comb begin
    set_v           = irq_src;
    set_v[EXT_IDX]  = set_v[EXT_IDX] | ext_evt;
    set_v[PERI_IDX] = set_v[PERI_IDX] | (|(peri_req & peri_q));

    clr_sw = '0;
    if (reg_wr && reg_addr == A_PEND_LO) clr_sw[REG_W-1:0]    = ~reg_wdata;
    if (reg_wr && reg_addr == A_PEND_HI) clr_sw[NSRC-1:REG_W] = ~reg_wdata;

    for (int i = 0; i < NSRC; i++) begin
      clr_ack[i] = ack && (ack_id == VEC_W'(i));
    end

    // a hardware set outranks both clear paths
    pend_d = set_v | (pend_q & ~clr_sw & ~clr_ack);

    ack_nmi    = ack && (ack_id == VEC_W'(VEC_NMI));
    ack_unimpl = ack && (ack_id == VEC_W'(VEC_UNIMPL));
    ack_sw     = ack && (ack_id == VEC_W'(VEC_SW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      mask_q   <= '0;
      peri_q   <= '0;
      ctrl_q   <= '0;
      nmi_q    <= 1'b0;
      unimpl_q <= 1'b0;
      sw_q     <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      nmi_q    <= nmi_evt | (nmi_q & ~ack_nmi);
      unimpl_q <= trap_unimpl | (unimpl_q & ~ack_unimpl);
      sw_q     <= trap_sw | (sw_q & ~ack_sw);
      if (reg_wr) begin
        case (reg_addr)
          A_MASK_LO: mask_q[REG_W-1:0]    <= reg_wdata;
          A_MASK_HI: mask_q[NSRC-1:REG_W] <= reg_wdata;
          A_PERI:    peri_q               <= reg_wdata[NPERI-1:0];
          A_CTRL:    ctrl_q               <= reg_wdata[CTRL_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK_LO: reg_rdata = mask_q[REG_W-1:0];
      A_PEND_LO: reg_rdata = pend_q[REG_W-1:0];
      A_MASK_HI: reg_rdata = mask_q[NSRC-1:REG_W];
      A_PEND_HI: reg_rdata = pend_q[NSRC-1:REG_W];
      A_PERI:    reg_rdata = REG_W'(peri_q);
      A_CTRL:    reg_rdata = REG_W'(ctrl_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign pend_o      = pend_q;
  assign mask_o      = mask_q;
  assign gie_o       = ctrl_q[CTRL_GIE];
  assign ext_level_o = ctrl_q[CTRL_LEVEL];
  assign ext_pol_o   = ctrl_q[CTRL_POL];
  assign nmi_p_o     = nmi_q;
  assign unimpl_p_o  = unimpl_q;
  assign sw_p_o      = sw_q;
endmodule

// File: rtl/icu_arb.sv
module icu_arb #(
  parameter int NSRC       = 16,
  parameter int VEC_W      = 5,
  parameter int VEC_UNIMPL = 16,
  parameter int VEC_SW     = 17,
  parameter int VEC_NMI    = 18
) (
  input  logic [NSRC-1:0]  req,
  input  logic             nmi_p,
  input  logic             unimpl_p,
  input  logic             sw_p,
  output logic             any,
  output logic [VEC_W-1:0] id
);
  // later assignments override earlier ones, so the scan runs from low to high priority
  always_comb begin
    any = 1'b0;
    id  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i]) begin
        any = 1'b1;
        id  = VEC_W'(i);
      end
    end
    if (sw_p) begin
      any = 1'b1;
      id  = VEC_W'(VEC_SW);
    end
    if (unimpl_p) begin
      any = 1'b1;
      id  = VEC_W'(VEC_UNIMPL);
    end
    if (nmi_p) begin
      any = 1'b1;
      id  = VEC_W'(VEC_NMI);
    end
  end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import icu_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int NPERI    = 5,
  parameter int EXT_IDX  = 2,
  parameter int PERI_IDX = 5,
  localparam int NSRC       = 2 * REG_W,
  localparam int VEC_UNIMPL = NSRC,
  localparam int VEC_SW     = NSRC + 1,
  localparam int VEC_NMI    = NSRC + 2,
  localparam int VEC_W      = $clog2(NSRC + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic [NPERI-1:0]  peri_req,
  input  logic              ext_pin,
  input  logic              nmi_pin,
  input  logic              trap_sw,
  input  logic              trap_unimpl,
  input  logic [1:0]        pwr_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [VEC_W-1:0]  vec_id,
  output logic              wake,
  output logic              wake_service
);
  logic [1:0]       pins_s;
  logic             ext_evt, nmi_evt;
  logic [NSRC-1:0]  pend, mask, req;
  logic             gie, ext_level, ext_pol, nmi_p, unimpl_p, sw_p;
  logic             arb_any;
  logic [VEC_W-1:0] arb_id;
  logic             vld_q, ack;
  logic [VEC_W-1:0] vec_q;

  icu_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({nmi_pin, ext_pin}), .q(pins_s)
  );

  icu_cond u_cond (
    .clk(clk), .rst_n(rst_n),
    .ext_s(pins_s[0]), .nmi_s(pins_s[1]),
    .level_mode(ext_level), .pol_high(ext_pol),
    .run_mode(pwr_mode == PM_RUN),
    .ext_evt(ext_evt), .nmi_evt(nmi_evt)
  );

  icu_regs #(
    .REG_W(REG_W), .NPERI(NPERI), .EXT_IDX(EXT_IDX), .PERI_IDX(PERI_IDX),
    .VEC_W(VEC_W), .VEC_UNIMPL(VEC_UNIMPL), .VEC_SW(VEC_SW), .VEC_NMI(VEC_NMI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .irq_src(irq_src), .peri_req(peri_req),
    .ext_evt(ext_evt), .nmi_evt(nmi_evt),
    .trap_sw(trap_sw), .trap_unimpl(trap_unimpl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ack(ack), .ack_id(vec_q),
    .pend_o(pend), .mask_o(mask), .gie_o(gie),
    .ext_level_o(ext_level), .ext_pol_o(ext_pol),
    .nmi_p_o(nmi_p), .unimpl_p_o(unimpl_p), .sw_p_o(sw_p)
  );

  assign req = pend & mask & {NSRC{gie}};

  icu_arb #(
    .NSRC(NSRC), .VEC_W(VEC_W),
    .VEC_UNIMPL(VEC_UNIMPL), .VEC_SW(VEC_SW), .VEC_NMI(VEC_NMI)
  ) u_arb (
    .req(req), .nmi_p(nmi_p), .unimpl_p(unimpl_p), .sw_p(sw_p),
    .any(arb_any), .id(arb_id)
  );

  // one-entry output slot; it reloads only from the empty state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else if (!vld_q) begin
      if (arb_any) begin
        vld_q <= 1'b1;
        vec_q <= arb_id;
      end
    end else if (vec_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign ack       = vld_q & vec_ready;
  assign vec_valid = vld_q;
  assign vec_id    = vec_q;

  always_comb begin
    wake         = 1'b0;
    wake_service = 1'b0;
    if (pwr_mode == PM_IDLE) begin
      wake = (|(pend & mask)) | nmi_p;
    end else if (pwr_mode == PM_DOWN) begin
      wake         = pend[EXT_IDX];
      wake_service = pend[EXT_IDX] & mask[EXT_IDX];
    end
  end
endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk #(
  parameter int VEC_W   = 5,
  parameter int VEC_MAX = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pwr_mode,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [VEC_W-1:0] vec_id,
  input logic             wake,
  input logic             wake_service
);
  // R5
  held_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_id));

  // R5
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> !vec_valid);

  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_id <= VEC_W'(VEC_MAX));

  // R12
  service_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_service |-> wake && pwr_mode == 2'd2);

  // R12
  run_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd1 && pwr_mode != 2'd2) |-> !wake);
endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.VEC_W(VEC_W), .VEC_MAX(VEC_NMI)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_id(vec_id),
  .wake(wake), .wake_service(wake_service)
);

// File: tb/irq_prio_ctl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_src = '0;
  logic [4:0]  peri_req = '0;
  logic        ext_pin = 1'b0, nmi_pin = 1'b0, trap_sw = 1'b0, trap_unimpl = 1'b0;
  logic [1:0]  pwr_mode = 2'd0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        vec_valid, vec_ready = 1'b0;
  logic [4:0]  vec_id;
  logic        wake, wake_service;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctl u_irq_prio_ctl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .peri_req(peri_req),
    .ext_pin(ext_pin), .nmi_pin(nmi_pin), .trap_sw(trap_sw), .trap_unimpl(trap_unimpl),
    .pwr_mode(pwr_mode), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_id(vec_id), .wake(wake), .wake_service(wake_service)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act %0d cycles exp finish", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_src(input logic [15:0] p);
    @(negedge clk); irq_src = p;
    @(negedge clk); irq_src = '0;
  endtask

  task automatic take();
    @(negedge clk); vec_ready = 1'b1;
    @(negedge clk); vec_ready = 1'b0;
    chk(!vec_valid, "R5 valid low after accept", vec_valid, 0);
    @(negedge clk);
  endtask

  task automatic chk_vec(input string req, input int exp);
    chk(vec_valid && vec_id == exp, req, vec_valid ? int'(vec_id) : -1, exp);
  endtask

  task automatic clear_pend();
    wr(3'd1, 8'h00); wr(3'd3, 8'h00);
  endtask

  function automatic int top_bit(input logic [15:0] v);
    int r = -1;
    for (int i = 0; i < 16; i++) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    logic [7:0] d;
    logic [15:0] p, m, rem;
    int b;
    cyc_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!vec_valid && !wake && !wake_service, "R1 outputs after reset", {vec_valid, wake, wake_service}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk(d == 8'h00, "R1 register reset", d, 0);
    end

    // R4 R2 sweep: pending/mask patterns, drained in descending order
    for (int k = 0; k < 40; k++) begin
      p = (k == 0) ? 16'hFFFF : 16'(k * 40503) ^ 16'(k << 5);
      m = (k == 1) ? 16'h0000 : (k == 0) ? 16'hFFFF : ~16'(k * 965) | 16'(k);
      wr(3'd5, 8'h00); wr(3'd0, m[7:0]); wr(3'd2, m[15:8]);
      pulse_src(p);
      rd(3'd1, d); chk(d == p[7:0], "R2 pending low byte", d, p[7:0]);
      rd(3'd3, d); chk(d == p[15:8], "R2 pending high byte", d, p[15:8]);
      chk(!vec_valid, "R4 nothing offered without global enable", vec_valid, 0);
      wr(3'd5, 8'h01);
      @(negedge clk);
      rem = p & m;
      while (rem != 0) begin
        b = top_bit(rem);
        chk_vec("R4 highest enabled index", b);
        take();
        rem[b] = 1'b0;
      end
      chk(!vec_valid, "R4 no vector after drain", vec_valid, 0);
      rd(3'd1, d); chk(d == (p[7:0] & ~m[7:0]), "R5 accepted bits cleared", d, p[7:0] & ~m[7:0]);
      clear_pend();
      wr(3'd5, 8'h00);
    end

    // R2 writing ones leaves bits, zeros clear
    pulse_src(16'h00A5);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk(d == 8'hA5, "R2 write one no effect", d, 8'hA5);
    wr(3'd1, 8'h0F); rd(3'd1, d); chk(d == 8'h05, "R2 write zero clears", d, 8'h05);
    clear_pend();

    // R3 set beats clear
    pulse_src(16'h0003);
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = 8'h00; reg_wr = 1'b1; irq_src = 16'h0002;
    @(negedge clk);
    reg_wr = 1'b0; irq_src = '0;
    rd(3'd1, d); chk(d == 8'h02, "R3 set wins over clear", d, 8'h02);
    clear_pend();

    // R6 peripheral mask
    pulse_src(16'h0000);
    @(negedge clk); peri_req = 5'h1F; @(negedge clk); peri_req = '0;
    rd(3'd1, d); chk(d[5] == 1'b0, "R6 masked peripheral ignored", d, 0);
    wr(3'd4, 8'h04);
    rd(3'd4, d); chk(d == 8'h04, "R6 peripheral mask readback", d, 8'h04);
    @(negedge clk); peri_req = 5'h1B; @(negedge clk); peri_req = '0;
    rd(3'd1, d); chk(d[5] == 1'b0, "R6 other peripheral bits ignored", d, 0);
    @(negedge clk); peri_req = 5'h04; @(negedge clk); peri_req = '0;
    rd(3'd1, d); chk(d == 8'h20, "R6 enabled peripheral sets bit 5", d, 8'h20);
    wr(3'd4, 8'h00); clear_pend();

    // R7 edge mode, rising then falling
    wr(3'd5, 8'h04);
    @(negedge clk); ext_pin = 1'b1; cyc_n(5);
    rd(3'd1, d); chk(d == 8'h04, "R7 rising edge sets bit 2", d, 8'h04);
    clear_pend(); cyc_n(4);
    rd(3'd1, d); chk(d == 8'h00, "R7 held level does not re-set in edge mode", d, 0);
    wr(3'd5, 8'h00); cyc_n(3);
    rd(3'd1, d); chk(d == 8'h00, "R7 polarity change no event", d, 0);
    @(negedge clk); ext_pin = 1'b0; cyc_n(5);
    rd(3'd1, d); chk(d == 8'h04, "R7 falling edge sets bit 2", d, 8'h04);
    clear_pend();

    // R8 level mode
    wr(3'd5, 8'h06);
    rd(3'd1, d); chk(d == 8'h00, "R8 inactive level no pending", d, 0);
    @(negedge clk); ext_pin = 1'b1; cyc_n(5);
    clear_pend();
    rd(3'd1, d); chk(d == 8'h04, "R8 clear does not stick while active", d, 8'h04);
    @(negedge clk); ext_pin = 1'b0; cyc_n(5);
    clear_pend();
    rd(3'd1, d); chk(d == 8'h00, "R8 clear sticks once inactive", d, 0);
    wr(3'd5, 8'h00);

    // R9 glitch ignored, two-sample pulse accepted
    @(negedge clk); nmi_pin = 1'b1; @(negedge clk); nmi_pin = 1'b0; cyc_n(8);
    chk(!vec_valid, "R9 one-cycle glitch ignored", vec_valid, 0);
    @(negedge clk); nmi_pin = 1'b1; cyc_n(2); nmi_pin = 1'b0; cyc_n(6);
    chk_vec("R9 nmi vector without enable", 18);
    take();
    pwr_mode = 2'd2;
    @(negedge clk); nmi_pin = 1'b1; cyc_n(4); nmi_pin = 1'b0; cyc_n(4);
    pwr_mode = 2'd0; cyc_n(6);
    chk(!vec_valid, "R9 edge outside run mode ignored", vec_valid, 0);

    // R10 priority drain while an earlier vector is held
    wr(3'd0, 8'h01);
    @(negedge clk); trap_sw = 1'b1; @(negedge clk); trap_sw = 1'b0; @(negedge clk);
    chk_vec("R10 software trap vector", 17);
    pulse_src(16'h0001);
    wr(3'd5, 8'h01);
    @(negedge clk); trap_unimpl = 1'b1; @(negedge clk); trap_unimpl = 1'b0;
    @(negedge clk); nmi_pin = 1'b1; cyc_n(3); nmi_pin = 1'b0; cyc_n(6);
    chk_vec("R5 held vector unchanged", 17);
    take(); chk_vec("R10 nmi first", 18);
    take(); chk_vec("R10 unimplemented trap next", 16);
    take(); chk_vec("R10 maskable last", 0);
    take();
    chk(!vec_valid, "R10 queue empty", vec_valid, 0);
    wr(3'd5, 8'h00); wr(3'd0, 8'h00); clear_pend();

    // R11 idle wakeup
    pwr_mode = 2'd1;
    wr(3'd0, 8'h10);
    pulse_src(16'h0080);
    chk(!wake, "R11 unmasked pending no wake", wake, 0);
    pulse_src(16'h0010);
    chk(wake, "R11 enabled pending wakes", wake, 1);
    pwr_mode = 2'd0; #1;
    chk(!wake, "R12 no wake in run mode", wake, 0);
    wr(3'd0, 8'h00); clear_pend();

    // R12 powerdown wakeup ignores mask
    wr(3'd5, 8'h04);
    pwr_mode = 2'd2;
    @(negedge clk); ext_pin = 1'b1; cyc_n(5);
    chk(wake && !wake_service, "R12 wake without service", {wake, wake_service}, 2);
    wr(3'd0, 8'h04);
    chk(wake && wake_service, "R12 wake with service", {wake, wake_service}, 3);
    pwr_mode = 2'd0; #1;
    chk(!wake && !wake_service, "R12 run mode outputs low", {wake, wake_service}, 0);
    ext_pin = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule